// File: doc/BRIEF.md
# Synchronous Buck Gate-Drive Sequencer

This block is the digital control core of a half-bridge driver for a synchronous buck stage. It takes two three-level control inputs. One is the switching command. The other selects the conduction mode: forced-continuous, diode-emulation, or shutdown. External comparators have already resolved each of them into a low, high or high-impedance code. From these inputs and from feedback flags it decides when the high-side and low-side gate enables turn on and off. The feedback flags report supply good, each gate below its threshold, the switch node low, and inductor current at zero.

Every timing rule is counted in cycles of a fast reference clock. A high-impedance command only takes effect after a hold-off, so a brief excursion through the middle band does nothing. Leaving that state also needs a short qualification. Handover between the switches is break-before-make and adapts to the gate and switch-node feedback. In diode emulation the low side keeps a guaranteed minimum on-time before a zero crossing may end it. A debug output shows the sequencer state.

Top module: `buck_gate_seq`

## Requirements
- R1: Input codes are 2'b00 low, 2'b01 high, 2'b10 high-impedance; 2'b11 is treated exactly as high-impedance. The state_o codes are 0 idle-off, 1 high-side on, 2 low-side on, 3 dead-time wait, 4 tri-state off, 5 shutdown. After reset both gate enables are low and state_o is 5.
- R2: With mode high (forced-continuous), a high switching command leads to hs_on_o=1 and ls_on_o=0, and a low command leads to hs_on_o=0 and ls_on_o=1.
- R3: On a command edge the conducting gate is dropped first, and the state becomes 3 with both enables low. hs_on_o rises only in the cycle after ls_gate_low_i was sampled high. ls_on_o rises only in the cycle after hs_gate_low_i and sw_node_low_i were both sampled high.
- R4: With mode low (diode emulation), a zero crossing ends low-side conduction and the state goes to 0. The state then stays at 0 with both enables low until the command goes high.
- R5: In diode emulation, ls_on_o stays high for at least LS_MIN_CYC cycles after it rises, whatever zero_cross_i does.
- R6: The command must be high-impedance for PWM_HOLD_CYC consecutive cycles before both enables drop and the state becomes 4. A shorter excursion leaves the outputs unchanged.
- R7: Leaving state 4 requires PWM_EXIT_CYC consecutive non-high-impedance command cycles.
- R8: Shutdown (state 5, both enables low) starts when mode has been high-impedance for SD_ENTER_CYC consecutive cycles. It ends once mode has been valid for SD_EXIT_CYC consecutive cycles. The block leaves reset in shutdown.
- R9: A low supply_ok_i forces state 5 with both enables low on the next cycle. Normal sequencing resumes once supply_ok_i is high again.
- R10: A zero crossing and a rising command in the same cycle are both honoured in order: the zero crossing ends low-side conduction first, and the high side then turns on through the normal handover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwm_i | input | 2 | Three-level switching command code |
| mode_i | input | 2 | Three-level conduction mode code (high forced-continuous, low diode emulation, high-impedance shutdown) |
| supply_ok_i | input | 1 | Driver supply above undervoltage threshold |
| hs_gate_low_i | input | 1 | High-side gate below turn-off threshold |
| ls_gate_low_i | input | 1 | Low-side gate below turn-off threshold |
| sw_node_low_i | input | 1 | Switch node below threshold |
| zero_cross_i | input | 1 | Inductor current has reached zero |
| hs_on_o | output | 1 | High-side gate enable |
| ls_on_o | output | 1 | Low-side gate enable |
| state_o | output | 3 | Sequencer state code |

## Verification
In diode emulation, two things can land on the same clock edge. A zero crossing can end low-side conduction on the edge where the minimum on-time expires, and a rising command can arrive on that edge too. The bench drives the rising command and the zero-crossing flag together on one falling edge. This happens once after the minimum on-time has elapsed, and repeatedly during a pseudo-random phase. The behavioural model then decides the expected result each cycle. It expects the idle-off state first and the high-side turn-on only after the low-side gate is reported low. A short high-impedance excursion that ends on the same edge as a command change is provoked the same way and judged by the same comparison.

// File: rtl/gd_pkg.sv
package gd_pkg;
  localparam int unsigned STATE_W = 3;
  typedef enum logic [STATE_W-1:0] {
    ST_OFF  = 3'd0,
    ST_HS   = 3'd1,
    ST_LS   = 3'd2,
    ST_DEAD = 3'd3,
    ST_TRI  = 3'd4,
    ST_SD   = 3'd5
  } gd_state_e;
endpackage

// File: rtl/gd_tri_qual.sv
module gd_tri_qual #(
  parameter int unsigned ENTER_CYC = 44,
  parameter int unsigned EXIT_CYC  = 9,
  parameter bit          RST_TRI   = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] code_i,
  output logic       tri_o,
  output logic       lvl_o
);
  localparam int unsigned MAX_CYC = (ENTER_CYC > EXIT_CYC) ? ENTER_CYC : EXIT_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] ENTER_LAST = CNT_W'(ENTER_CYC - 1);
  localparam logic [CNT_W-1:0] EXIT_LAST  = CNT_W'(EXIT_CYC - 1);

  logic             hiz;
  logic             tri_q, lvl_q;
  logic [CNT_W-1:0] cnt_q, limit;

  // 2'b10 and 2'b11 both read as high-impedance
  assign hiz   = code_i[1];
  assign limit = tri_q ? EXIT_LAST : ENTER_LAST;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tri_q <= RST_TRI;
      lvl_q <= 1'b0;
    end else begin
      if (hiz != tri_q) begin
        if (cnt_q == limit) begin
          tri_q <= hiz;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
      if (!hiz) lvl_q <= code_i[0];
    end
  end

  assign tri_o = tri_q;
  assign lvl_o = lvl_q;

  // R6
  tri_enter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tri_q) |-> $past(hiz));
  // R7
  tri_leave_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tri_q) |-> $past(!hiz));
  // R6
  lvl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lvl_q) |-> $past(!hiz));
endmodule

// File: rtl/gd_min_on.sv
module gd_min_on #(
  parameter int unsigned MIN_CYC = 88
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned CNT_W = $clog2(MIN_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MIN_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (!run_i)       cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  // saturates at LAST, so equality means elapsed
  assign done_o = (cnt_q == LAST);
endmodule

// File: rtl/buck_gate_seq.sv
module buck_gate_seq
  import gd_pkg::*;
#(
  parameter int unsigned PWM_HOLD_CYC = 44,
  parameter int unsigned PWM_EXIT_CYC = 9,
  parameter int unsigned SD_ENTER_CYC = 625,
  parameter int unsigned SD_EXIT_CYC  = 625,
  parameter int unsigned LS_MIN_CYC   = 88
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         pwm_i,
  input  logic [1:0]         mode_i,
  input  logic               supply_ok_i,
  input  logic               hs_gate_low_i,
  input  logic               ls_gate_low_i,
  input  logic               sw_node_low_i,
  input  logic               zero_cross_i,
  output logic               hs_on_o,
  output logic               ls_on_o,
  output logic [STATE_W-1:0] state_o
);
  logic      pwm_tri, pwm_hi, mode_sd, mode_ccm;
  logic      ls_run, ls_done, emul;
  gd_state_e state_q, state_d;

  gd_tri_qual #(
    .ENTER_CYC(PWM_HOLD_CYC), .EXIT_CYC(PWM_EXIT_CYC), .RST_TRI(1'b0)
  ) u_pwm_qual (
    .clk_i, .rst_ni, .code_i(pwm_i), .tri_o(pwm_tri), .lvl_o(pwm_hi)
  );

  gd_tri_qual #(
    .ENTER_CYC(SD_ENTER_CYC), .EXIT_CYC(SD_EXIT_CYC), .RST_TRI(1'b1)
  ) u_mode_qual (
    .clk_i, .rst_ni, .code_i(mode_i), .tri_o(mode_sd), .lvl_o(mode_ccm)
  );

  assign ls_run = (state_q == ST_LS);

  gd_min_on #(.MIN_CYC(LS_MIN_CYC)) u_min_on (
    .clk_i, .rst_ni, .run_i(ls_run), .done_o(ls_done)
  );

  assign emul = !mode_ccm;

  always_comb begin
    state_d = state_q;
    if (!supply_ok_i || mode_sd) begin
      state_d = ST_SD;
    end else if (pwm_tri) begin
      state_d = ST_TRI;
    end else begin
      unique case (state_q)
        ST_HS: state_d = pwm_hi ? ST_HS : ST_DEAD;
        ST_LS: begin
          if (pwm_hi)                             state_d = ST_DEAD;
          else if (emul && zero_cross_i && ls_done) state_d = ST_OFF;
          else                                    state_d = ST_LS;
        end
        default: begin
          // all gates off: wait for the off-going side before making
          if (pwm_hi)
            state_d = ls_gate_low_i ? ST_HS : ST_DEAD;
          else if (state_q == ST_OFF && emul)
            state_d = ST_OFF;
          else
            state_d = (hs_gate_low_i && sw_node_low_i) ? ST_LS : ST_DEAD;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_SD;
    else         state_q <= state_d;
  end

  assign hs_on_o = (state_q == ST_HS);
  assign ls_on_o = (state_q == ST_LS);
  assign state_o = state_q;

  // R3
  hs_make_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_on_o) |-> $past(ls_gate_low_i));
  // R3
  ls_make_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ls_on_o) |-> $past(hs_gate_low_i && sw_node_low_i));
  // R9
  uv_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> (!hs_on_o && !ls_on_o));
  // R8
  sd_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_sd |=> (state_q == ST_SD));
  // R5
  min_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ls_on_o) && $past(!pwm_hi && !pwm_tri && !mode_sd && supply_ok_i))
      |-> $past(ls_done));
  // R6
  tri_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_tri && supply_ok_i && !mode_sd) |=> (state_q == ST_TRI));
endmodule

// File: tb/test_buck_gate_seq.sv
module test_buck_gate_seq;
  localparam int HOLD = 6, EXITC = 3, SDIN = 12, SDOUT = 10, MINON = 8;
  localparam int S_OFF = 0, S_HS = 1, S_LS = 2, S_DEAD = 3, S_TRI = 4, S_SD = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] pwm = 2'b00, mode = 2'b01;
  logic uv_ok = 1'b1, hs_low = 1'b1, ls_low = 1'b1, sw_low = 1'b1, zc = 1'b0;
  logic hs_on, ls_on;
  logic [2:0] st;
  logic sw_stuck = 1'b0;
  logic [1:0] gh_h = '0, gl_h = '0;
  int checks = 0, errors = 0;
  string phase = "R1";

  always #2 clk = ~clk;

  buck_gate_seq #(
    .PWM_HOLD_CYC(HOLD), .PWM_EXIT_CYC(EXITC), .SD_ENTER_CYC(SDIN),
    .SD_EXIT_CYC(SDOUT), .LS_MIN_CYC(MINON)
  ) i_buck_gate_seq (
    .clk_i(clk), .rst_ni(rst_n), .pwm_i(pwm), .mode_i(mode),
    .supply_ok_i(uv_ok), .hs_gate_low_i(hs_low), .ls_gate_low_i(ls_low),
    .sw_node_low_i(sw_low), .zero_cross_i(zc),
    .hs_on_o(hs_on), .ls_on_o(ls_on), .state_o(st)
  );

  // behavioural reference model
  int m_st, m_lscnt, m_ptri, m_pcnt, m_plvl, m_fsd, m_fcnt, m_flvl;
  always @(posedge clk or negedge rst_n) begin
    int nst, lim;
    if (!rst_n) begin
      m_st = S_SD; m_lscnt = 0; m_ptri = 0; m_pcnt = 0; m_plvl = 0;
      m_fsd = 1; m_fcnt = 0; m_flvl = 0;
    end else begin
      if (!uv_ok || m_fsd == 1) nst = S_SD;
      else if (m_ptri == 1) nst = S_TRI;
      else if (m_st == S_HS) nst = (m_plvl == 1) ? S_HS : S_DEAD;
      else if (m_st == S_LS) begin
        if (m_plvl == 1) nst = S_DEAD;
        else if (m_flvl == 0 && zc && m_lscnt >= MINON - 1) nst = S_OFF;
        else nst = S_LS;
      end else if (m_plvl == 1) nst = ls_low ? S_HS : S_DEAD;
      else if (m_st == S_OFF && m_flvl == 0) nst = S_OFF;
      else nst = (hs_low && sw_low) ? S_LS : S_DEAD;
      m_lscnt = (m_st == S_LS) ? ((m_lscnt < MINON - 1) ? m_lscnt + 1 : m_lscnt) : 0;
      lim = (m_ptri == 1) ? EXITC : HOLD;
      if (int'(pwm[1]) != m_ptri) begin
        if (m_pcnt == lim - 1) begin m_ptri = pwm[1]; m_pcnt = 0; end
        else m_pcnt++;
      end else m_pcnt = 0;
      if (!pwm[1]) m_plvl = pwm[0];
      lim = (m_fsd == 1) ? SDOUT : SDIN;
      if (int'(mode[1]) != m_fsd) begin
        if (m_fcnt == lim - 1) begin m_fsd = mode[1]; m_fcnt = 0; end
        else m_fcnt++;
      end else m_fcnt = 0;
      if (!mode[1]) m_flvl = mode[0];
      m_st = nst;
    end
  end

  // per-cycle comparison and gate/switch-node feedback
  always @(negedge clk) begin
    logic nh;
    if (rst_n) begin
      checks++;
      if (hs_on !== (m_st == S_HS) || ls_on !== (m_st == S_LS) || st !== 3'(m_st)) begin
        errors++;
        $display("FAIL %s: hs=%0b ls=%0b st=%0d expected hs=%0b ls=%0b st=%0d",
                 phase, hs_on, ls_on, st, m_st == S_HS, m_st == S_LS, m_st);
      end
    end
    nh = !(hs_on | gh_h[0] | gh_h[1]);
    hs_low <= nh;
    sw_low <= nh && !sw_stuck;
    ls_low <= !(ls_on | gl_h[0] | gl_h[1]);
    gh_h <= {gh_h[0], hs_on};
    gl_h <= {gl_h[0], ls_on};
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_st(input int exp, input string req);
    checks++;
    if (st !== 3'(exp)) begin
      errors++;
      $display("FAIL %s: state=%0d expected %0d", req, st, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(3);
    checks++;
    if (hs_on !== 1'b0 || ls_on !== 1'b0 || st !== 3'd5) begin
      errors++;
      $display("FAIL R1: hs=%0b ls=%0b st=%0d expected 0 0 5", hs_on, ls_on, st);
    end
    rst_n = 1'b1;
    step(2); expect_st(S_SD, "R8");            // still qualifying mode exit
    phase = "R2"; step(20); expect_st(S_LS, "R2");
    pwm = 2'b01; step(8); expect_st(S_HS, "R2");
    pwm = 2'b00; step(8); expect_st(S_LS, "R2");
    pwm = 2'b01; step(3); pwm = 2'b00; step(4); pwm = 2'b01; step(8); expect_st(S_HS, "R2");

    phase = "R3"; sw_stuck = 1'b1; pwm = 2'b00; step(10); expect_st(S_DEAD, "R3");
    sw_stuck = 1'b0; step(5); expect_st(S_LS, "R3");

    phase = "R6"; pwm = 2'b01; step(8);
    pwm = 2'b10; step(HOLD - 2); pwm = 2'b01; step(1); expect_st(S_HS, "R6");
    step(4); expect_st(S_HS, "R6");
    pwm = 2'b10; step(HOLD + 4); expect_st(S_TRI, "R6");

    phase = "R7"; pwm = 2'b01; step(EXITC - 1); expect_st(S_TRI, "R7");
    pwm = 2'b10; step(2); pwm = 2'b01; step(EXITC + 6); expect_st(S_HS, "R7");

    phase = "R1"; pwm = 2'b11; step(HOLD + 4); expect_st(S_TRI, "R1");
    pwm = 2'b00; step(EXITC + 8); expect_st(S_LS, "R1");

    phase = "R5"; mode = 2'b00; step(2); pwm = 2'b01; step(8); expect_st(S_HS, "R5");
    pwm = 2'b00; zc = 1'b1; step(4 + MINON / 2); expect_st(S_LS, "R5");
    phase = "R4"; step(MINON + 2); expect_st(S_OFF, "R4");
    step(10); expect_st(S_OFF, "R4");
    zc = 1'b0; pwm = 2'b01; step(8); expect_st(S_HS, "R4");

    phase = "R10"; pwm = 2'b00; step(MINON + 10); expect_st(S_LS, "R10");
    pwm = 2'b01; zc = 1'b1; step(1); zc = 1'b0; step(8); expect_st(S_HS, "R10");

    phase = "R8"; mode = 2'b10; step(SDIN + 2); expect_st(S_SD, "R8");
    mode = 2'b01; step(SDOUT - 4); expect_st(S_SD, "R8");
    step(12); expect_st(S_HS, "R8");

    phase = "R9"; uv_ok = 1'b0; step(1); expect_st(S_SD, "R9");
    uv_ok = 1'b1; step(8); expect_st(S_HS, "R9");

    phase = "R10";
    for (int i = 0; i < 600; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 40)      pwm = 2'b00;
      else if (r < 80) pwm = 2'b01;
      else if (r < 95) pwm = 2'b10;
      else             pwm = 2'b11;
      zc = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 49) == 0) mode = {1'b0, ~mode[0]};
      sw_stuck = ($urandom_range(0, 9) == 0);
      uv_ok = ($urandom_range(0, 99) != 0);
      step($urandom_range(1, 12));
    end
    uv_ok = 1'b1; sw_stuck = 1'b0; zc = 1'b0;
    step(20);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule